// File: doc/BRIEF.md
# Protected Switch Routing Controller

This block turns two host-written configuration registers into close commands for the analog switch matrix behind a reversible connector. The matrix has two data pins, each routed to a USB host pair or to an audio channel, two sideband pins, and a guard-pin sense path. Each sideband pin can carry a microphone, an analog ground, or one or both host sideband lines. The block also produces compact read-only status codes that describe each pin's routing.

Protection inputs arrive as plain digital levels from the comparators. When over-voltage is seen on a pin group and protection is on, that group opens in the same cycle. It then stays locked open until the host rewrites the select register while the fault input is low. A debounced over-current on the ground connection clears the ground enable bit, so only a fresh host write closes it again. Every event latches a flag, and the host clears the flags by reading them.

Top module: `swr_ctrl`

## Requirements
- R1: After reset the enable register holds 8'b1001_1000 and the select register holds 8'b0001_1000. Enable bits: 7 master, 6 host sideband 1, 5 host sideband 2, 4 left data, 3 right data, 2 sense, 1 mic, 0 ground. Select bits use the same positions 6..0. So after reset both data pins route to the USB host, and the sense and sideband pins are open.
- R2: A data pin is closed only when the master bit and its own enable bit are both 1. Select 1 routes it to the USB host (close bit 0) and select 0 routes it to audio (close bit 1). At most one close bit is high.
- R3: The left, right and sense status fields are 2 bits: 00 open, 01 first target, 10 second target. The first target is the USB host for data pins and guard pin 1 for sense. Sense select 0 picks guard pin 1 and select 1 picks guard pin 2. Code 11 never appears.
- R4: Host sideband 1 goes to sideband pin 1 when its select is 0 and to pin 2 when its select is 1. Host sideband 2 goes to pin 2 when its select is 0 and to pin 1 when its select is 1. The 3-bit pin codes are 000 open, 001 mic, 010 ground, 011 host sideband 1, 100 host sideband 2 and 101 both host sidebands. Codes 110 and 111 never appear. Close vector bits are 0 mic, 1 ground, 2 host sideband 1, 3 host sideband 2.
- R5: While either host sideband enable is 1, the mic and the ground stay open on both pins, whatever their own enables say.
- R6: Mic select 1 picks pin 1 and mic select 0 picks pin 2. Ground select 0 picks pin 1 and ground select 1 picks pin 2. If both are enabled and land on the same pin, the mic stays open and the ground is still closed.
- R7: Over-voltage lanes are 0 data pins, 1 sideband pin 1, 2 sideband pin 2, 3 guard pins. With over-voltage protection enabled, a high lane input opens its paths in the same cycle and sets flag bit equal to the lane index. The lane stays open until a select-register write made while its input is low. A write made while the input is still high leaves the lane open. With protection disabled the input has no effect.
- R8: With over-current protection enabled, the over-current input of the pin that carries the ground must stay high for OCP_DEBOUNCE consecutive cycles. The block then clears enable bit 0, which opens the ground, and sets flag 4 for pin 1 or flag 5 for pin 2. A shorter run, an input on the other pin, or protection disabled has no effect. Writing enable bit 0 as 1 closes the ground again.
- R9: Flags clear when the host pulses the read strobe. A flag set in the same cycle as the read survives. The interrupt output is the OR of all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| sel_wr | input | 1 | Write strobe for the select register |
| wdata | input | 8 | Write data |
| irq_rd | input | 1 | Flag read strobe, clears the flags |
| ovp_en | input | 1 | Over-voltage protection enable |
| ocp_en | input | 1 | Over-current protection enable |
| ovp_hit | input | 4 | Over-voltage comparator levels per lane |
| ocp_hit | input | 2 | Over-current comparator levels per sideband pin |
| close_left | output | 2 | Left data pin close commands |
| close_right | output | 2 | Right data pin close commands |
| close_sense | output | 2 | Sense path close commands |
| close_sbu1 | output | 4 | Sideband pin 1 close commands |
| close_sbu2 | output | 4 | Sideband pin 2 close commands |
| stat_left | output | 2 | Left data pin status code |
| stat_right | output | 2 | Right data pin status code |
| stat_sense | output | 2 | Sense path status code |
| stat_sbu1 | output | 3 | Sideband pin 1 status code |
| stat_sbu2 | output | 3 | Sideband pin 2 status code |
| irq_flags | output | 6 | Latched event flags |
| irq | output | 1 | OR of all flags |

## Verification
The bench builds the block with OCP_DEBOUNCE set to 4. At that value the exact trip cycle, a run one cycle too short, and the counter restart after a gap all fit into a few cycles. With protection idle, it sweeps all 65,536 pairs of enable and select values and compares every status code against an arithmetic model of the routing rules. Directed sequences then cover lockout and restore on each protection path and the read-clear race.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] EN_RST  = 8'b1001_1000;
  localparam logic [REG_W-1:0] SEL_RST = 8'b0001_1000;

  localparam int B_MASTER = 7;
  localparam int B_HS1    = 6;
  localparam int B_HS2    = 5;
  localparam int B_LEFT   = 4;
  localparam int B_RIGHT  = 3;
  localparam int B_SENSE  = 2;
  localparam int B_MIC    = 1;
  localparam int B_GND    = 0;

  localparam int LN_DATA  = 0;
  localparam int LN_SBU1  = 1;
  localparam int LN_SBU2  = 2;
  localparam int LN_GUARD = 3;
  localparam int N_LANE   = 4;
  localparam int N_PIN    = 2;
  localparam int N_FLAG   = N_LANE + N_PIN;

  typedef struct packed {
    logic hs2;
    logic hs1;
    logic gnd;
    logic mic;
  } sbu_close_t;

  function automatic logic [2:0] enc_sbu(input sbu_close_t c);
    if (c.hs1 && c.hs2) return 3'b101;
    if (c.hs2)          return 3'b100;
    if (c.hs1)          return 3'b011;
    if (c.gnd)          return 3'b010;
    if (c.mic)          return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [1:0] enc_pair(input logic [1:0] c);
    if (c[0]) return 2'b01;
    if (c[1]) return 2'b10;
    return 2'b00;
  endfunction
endpackage

// File: rtl/swr_regs.sv
module swr_regs
  import swr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             sel_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ocp_trip,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_RST;
      sel_q <= SEL_RST;
    end else begin
      if (en_wr)    en_q <= wdata;
      if (ocp_trip) en_q[B_GND] <= 1'b0;
      if (sel_wr)   sel_q <= wdata;
    end
  end

  // R8: a trip beats a simultaneous host write of the ground enable
  a_r8_trip_clears_gnd: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_trip |=> !en_q[B_GND]);
endmodule

// File: rtl/swr_route.sv
module swr_route
  import swr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  en_q,
  input  logic [REG_W-1:0]  sel_q,
  input  logic [N_LANE-1:0] block,
  output logic [1:0]        close_left,
  output logic [1:0]        close_right,
  output logic [1:0]        close_sense,
  output sbu_close_t        close_sbu1,
  output sbu_close_t        close_sbu2
);
  logic master, hs_any, hs1_on, hs2_on, mic_req, gnd_req, clash, mic_ok;
  logic left_on, right_on, sense_on;
  sbu_close_t raw1, raw2;

  always_comb begin
    master   = en_q[B_MASTER];
    left_on  = master & en_q[B_LEFT]  & ~block[LN_DATA];
    right_on = master & en_q[B_RIGHT] & ~block[LN_DATA];
    sense_on = master & en_q[B_SENSE] & ~block[LN_GUARD];
    hs1_on   = master & en_q[B_HS1];
    hs2_on   = master & en_q[B_HS2];
    hs_any   = en_q[B_HS1] | en_q[B_HS2];
    mic_req  = master & en_q[B_MIC] & ~hs_any;
    gnd_req  = master & en_q[B_GND] & ~hs_any;
    // mic on pin 1 when its select is 1, ground on pin 1 when its select is 0
    clash    = mic_req & gnd_req & (sel_q[B_MIC] ^ sel_q[B_GND]);
    mic_ok   = mic_req & ~clash;

    close_left  = {~sel_q[B_LEFT],  sel_q[B_LEFT]}  & {2{left_on}};
    close_right = {~sel_q[B_RIGHT], sel_q[B_RIGHT]} & {2{right_on}};
    close_sense = {sel_q[B_SENSE], ~sel_q[B_SENSE]} & {2{sense_on}};

    raw1.hs1 = hs1_on  & ~sel_q[B_HS1];
    raw1.hs2 = hs2_on  &  sel_q[B_HS2];
    raw1.gnd = gnd_req & ~sel_q[B_GND];
    raw1.mic = mic_ok  &  sel_q[B_MIC];
    raw2.hs1 = hs1_on  &  sel_q[B_HS1];
    raw2.hs2 = hs2_on  & ~sel_q[B_HS2];
    raw2.gnd = gnd_req &  sel_q[B_GND];
    raw2.mic = mic_ok  & ~sel_q[B_MIC];

    close_sbu1 = block[LN_SBU1] ? '0 : raw1;
    close_sbu2 = block[LN_SBU2] ? '0 : raw2;
  end

  a_r5_hs_excludes_mic_gnd: assert property (@(posedge clk) disable iff (!rst_n)
    (close_sbu1.hs1 | close_sbu1.hs2 | close_sbu2.hs1 | close_sbu2.hs2) |->
    !(close_sbu1.mic | close_sbu1.gnd | close_sbu2.mic | close_sbu2.gnd));
  a_r6_no_mic_gnd_share: assert property (@(posedge clk) disable iff (!rst_n)
    !(close_sbu1.mic && close_sbu1.gnd) && !(close_sbu2.mic && close_sbu2.gnd));
  a_r2_data_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(close_left) && $onehot0(close_right) && $onehot0(close_sense));
endmodule

// File: rtl/swr_guard.sv
module swr_guard
  import swr_pkg::*;
#(
  parameter int OCP_DEBOUNCE = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovp_en,
  input  logic              ocp_en,
  input  logic [N_LANE-1:0] ovp_hit,
  input  logic [N_PIN-1:0]  ocp_hit,
  input  logic [N_PIN-1:0]  gnd_on,
  input  logic              sel_wr,
  input  logic              irq_rd,
  output logic [N_LANE-1:0] block,
  output logic              ocp_trip,
  output logic [N_FLAG-1:0] flags
);
  localparam int CNT_W = $clog2(OCP_DEBOUNCE + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OCP_DEBOUNCE - 1);

  logic [N_LANE-1:0] ovp_set, lock;
  logic [N_PIN-1:0]  ocp_cond;
  logic [N_FLAG-1:0] flag_set;
  logic [CNT_W-1:0]  cnt;
  logic              cond_any;

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    assign ovp_set[i] = ovp_en & ovp_hit[i];
    assign block[i]   = lock[i] | ovp_set[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      lock[i] <= 1'b0;
      else if (ovp_set[i])             lock[i] <= 1'b1;
      else if (sel_wr && !ovp_hit[i])  lock[i] <= 1'b0;
    end
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock[i] && !sel_wr |=> lock[i]);
  end

  assign ocp_cond = {N_PIN{ocp_en}} & gnd_on & ocp_hit;
  assign cond_any = |ocp_cond;
  assign ocp_trip = cond_any && (cnt == CNT_LAST);
  assign flag_set = {ocp_cond & {N_PIN{ocp_trip}}, ovp_set};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!cond_any || ocp_trip) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (irq_rd ? '0 : flags) | flag_set;
  end

  a_r9_read_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd && (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));
  a_r8_no_trip_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ocp_en |-> !ocp_trip);
endmodule

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
#(
  parameter int OCP_DEBOUNCE = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        sel_wr,
  input  logic [7:0]  wdata,
  input  logic        irq_rd,
  input  logic        ovp_en,
  input  logic        ocp_en,
  input  logic [3:0]  ovp_hit,
  input  logic [1:0]  ocp_hit,
  output logic [1:0]  close_left,
  output logic [1:0]  close_right,
  output logic [1:0]  close_sense,
  output logic [3:0]  close_sbu1,
  output logic [3:0]  close_sbu2,
  output logic [1:0]  stat_left,
  output logic [1:0]  stat_right,
  output logic [1:0]  stat_sense,
  output logic [2:0]  stat_sbu1,
  output logic [2:0]  stat_sbu2,
  output logic [5:0]  irq_flags,
  output logic        irq
);
  logic [REG_W-1:0]  en_q, sel_q;
  logic [N_LANE-1:0] block;
  logic              ocp_trip;
  sbu_close_t        c1, c2;

  swr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .sel_wr(sel_wr), .wdata(wdata),
    .ocp_trip(ocp_trip), .en_q(en_q), .sel_q(sel_q));

  swr_route u_route (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .sel_q(sel_q), .block(block),
    .close_left(close_left), .close_right(close_right), .close_sense(close_sense),
    .close_sbu1(c1), .close_sbu2(c2));

  swr_guard #(.OCP_DEBOUNCE(OCP_DEBOUNCE)) u_guard (
    .clk(clk), .rst_n(rst_n), .ovp_en(ovp_en), .ocp_en(ocp_en),
    .ovp_hit(ovp_hit), .ocp_hit(ocp_hit), .gnd_on({c2.gnd, c1.gnd}),
    .sel_wr(sel_wr), .irq_rd(irq_rd), .block(block), .ocp_trip(ocp_trip),
    .flags(irq_flags));

  assign close_sbu1 = c1;
  assign close_sbu2 = c2;
  assign stat_left  = enc_pair(close_left);
  assign stat_right = enc_pair(close_right);
  assign stat_sense = enc_pair(close_sense);
  assign stat_sbu1  = enc_sbu(c1);
  assign stat_sbu2  = enc_sbu(c2);
  assign irq        = |irq_flags;

  a_r7_ovp_opens_now: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_en && ovp_hit[LN_DATA] |-> (close_left == 2'b00) && (close_right == 2'b00));
  a_r7_ovp_opens_sbu1: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_en && ovp_hit[LN_SBU1] |-> (close_sbu1 == 4'b0000));
  a_r9_irq_follows_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags != 6'd0) |-> irq);
endmodule

// File: tb/tb_swr_ctrl.sv
`timescale 1ns/1ps
module tb_swr_ctrl;
  localparam int DEB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_wr = 0, sel_wr = 0, irq_rd = 0, ovp_en = 0, ocp_en = 0;
  logic [7:0] wdata = '0;
  logic [3:0] ovp_hit = '0;
  logic [1:0] ocp_hit = '0;
  logic [1:0] close_left, close_right, close_sense, stat_left, stat_right, stat_sense;
  logic [3:0] close_sbu1, close_sbu2;
  logic [2:0] stat_sbu1, stat_sbu2;
  logic [5:0] irq_flags;
  logic irq;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  swr_ctrl #(.OCP_DEBOUNCE(DEB)) dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); en_wr = 1; wdata = v;
    @(posedge clk); #1; en_wr = 0;
  endtask

  task automatic wr_sel(input logic [7:0] v);
    @(negedge clk); sel_wr = 1; wdata = v;
    @(posedge clk); #1; sel_wr = 0;
  endtask

  task automatic rd_flags();
    @(negedge clk); irq_rd = 1;
    @(posedge clk); #1; irq_rd = 0;
  endtask

  // Model of the routing rules, written as pin arithmetic
  function automatic void model(input logic [7:0] e, input logic [7:0] s,
      output int l, output int r, output int se, output int p1, output int p2);
    int m, h1, h2, g, mc, hpin1, hpin2, gpin, mpin;
    m  = e[7];
    l  = (m && e[4]) ? (s[4] ? 1 : 2) : 0;
    r  = (m && e[3]) ? (s[3] ? 1 : 2) : 0;
    se = (m && e[2]) ? (s[2] ? 2 : 1) : 0;
    h1 = m & e[6]; h2 = m & e[5];
    g  = m & e[0] & ~(e[6] | e[5]);
    gpin = s[0] ? 2 : 1;
    mpin = s[1] ? 1 : 2;
    mc = m & e[1] & ~(e[6] | e[5]);
    if (g && mc && gpin == mpin) mc = 0;
    hpin1 = s[6] ? 2 : 1;
    hpin2 = s[5] ? 1 : 2;
    for (int p = 1; p <= 2; p++) begin
      int code;
      bit a, b;
      a = h1 && hpin1 == p;
      b = h2 && hpin2 == p;
      if (a && b) code = 5;
      else if (b) code = 4;
      else if (a) code = 3;
      else if (g && gpin == p) code = 2;
      else if (mc && mpin == p) code = 1;
      else code = 0;
      if (p == 1) p1 = code; else p2 = code;
    end
  endfunction

  initial begin
    int l, r, se, p1, p2;
    do_reset();
    // R1 reset state
    chk("R1 stat_left", stat_left, 1);
    chk("R1 stat_right", stat_right, 1);
    chk("R1 stat_sense", stat_sense, 0);
    chk("R1 stat_sbu1", stat_sbu1, 0);
    chk("R1 stat_sbu2", stat_sbu2, 0);
    chk("R9 flags after reset", irq_flags, 0);

    // R2 R3 R4 R5 R6 full sweep of both registers
    for (int e = 0; e < 256; e++) begin
      wr_en(8'(e));
      for (int s = 0; s < 256; s++) begin
        wr_sel(8'(s));
        model(8'(e), 8'(s), l, r, se, p1, p2);
        chk("R2 R3 left", stat_left, l);
        chk("R2 R3 right", stat_right, r);
        chk("R3 sense", stat_sense, se);
        chk("R4 R5 R6 sbu1", stat_sbu1, p1);
        chk("R4 R5 R6 sbu2", stat_sbu2, p2);
      end
    end

    // R7 over-voltage lockout on the data lane
    do_reset();
    ovp_en = 1;
    @(negedge clk); ovp_hit = 4'b0001; #1;
    chk("R7 opens same cycle", stat_left, 0);
    @(negedge clk);
    chk("R7 flag data lane", irq_flags, 1);
    chk("R9 irq", irq, 1);
    wr_sel(8'h18);
    @(negedge clk); ovp_hit = 4'b0000; #1;
    chk("R7 write during fault keeps lock", stat_left, 0);
    wr_sel(8'h18);
    chk("R7 restore after clear write", stat_left, 1);
    rd_flags();
    chk("R9 read clears", irq_flags, 0);
    chk("R9 irq low", irq, 0);
    // R9 flag set in the read cycle survives
    @(negedge clk); ovp_hit = 4'b0010; irq_rd = 1;
    @(posedge clk); #1; irq_rd = 0;
    chk("R9 same-cycle set survives", irq_flags, 2);
    @(negedge clk); ovp_hit = 4'b0000;
    wr_sel(8'h18);
    rd_flags();
    chk("R9 cleared again", irq_flags, 0);
    // R7 disabled protection ignores the input
    ovp_en = 0;
    @(negedge clk); ovp_hit = 4'b0001;
    @(negedge clk);
    chk("R7 disabled no open", stat_left, 1);
    chk("R7 disabled no flag", irq_flags, 0);
    ovp_hit = 4'b0000; ovp_en = 1;
    // R7 guard lane on sense
    wr_en(8'h84);
    chk("R3 sense to guard1", stat_sense, 1);
    @(negedge clk); ovp_hit = 4'b1000; #1;
    chk("R7 guard lane opens", stat_sense, 0);
    @(negedge clk); ovp_hit = 4'b0000;
    chk("R7 guard flag", irq_flags, 8);
    wr_sel(8'h18);
    chk("R7 guard restore", stat_sense, 1);
    rd_flags();

    // R8 over-current debounce on ground at sideband pin 1
    ocp_en = 1;
    wr_en(8'h81);
    wr_sel(8'h00);
    chk("R8 ground on sbu1", stat_sbu1, 2);
    @(negedge clk); ocp_hit = 2'b01;
    repeat (DEB - 1) @(posedge clk);
    #1;
    chk("R8 one short of debounce", stat_sbu1, 2);
    @(posedge clk); #1;
    chk("R8 trips at debounce", stat_sbu1, 0);
    chk("R8 flag pin1", irq_flags, 16);
    @(negedge clk); ocp_hit = 2'b00;
    repeat (3) @(negedge clk);
    chk("R8 no self re-arm", stat_sbu1, 0);
    wr_en(8'h81);
    chk("R8 reclose by write", stat_sbu1, 2);
    rd_flags();
    // R8 interrupted runs restart the count
    @(negedge clk); ocp_hit = 2'b01;
    repeat (DEB - 1) @(posedge clk);
    #1; ocp_hit = 2'b00;
    @(posedge clk); #1;
    @(negedge clk); ocp_hit = 2'b01;
    repeat (DEB - 1) @(posedge clk);
    #1; ocp_hit = 2'b00;
    chk("R8 gap resets count", stat_sbu1, 2);
    // R8 other pin and disabled protection
    @(negedge clk); ocp_hit = 2'b10;
    repeat (2 * DEB) @(negedge clk);
    chk("R8 other pin ignored", stat_sbu1, 2);
    ocp_hit = 2'b01; ocp_en = 0;
    repeat (2 * DEB) @(negedge clk);
    chk("R8 disabled ignored", stat_sbu1, 2);
    chk("R8 no flags", irq_flags, 0);
    ocp_hit = 2'b00; ocp_en = 1;
    // R8 ground on sideband pin 2
    wr_sel(8'h01);
    chk("R6 ground on sbu2", stat_sbu2, 2);
    @(negedge clk); ocp_hit = 2'b10;
    repeat (DEB) @(posedge clk);
    #1;
    chk("R8 trips pin2", stat_sbu2, 0);
    chk("R8 flag pin2", irq_flags, 32);
    ocp_hit = 2'b00;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule